// File: doc/BRIEF.md
# Transition-Mode Boost Gate Sequencer

This block decides, clock by clock, when the switch of a boost power-factor stage turns on and off in transition (critical-conduction) mode. All of its inputs are single-bit levels already synchronised to the clock: the demagnetisation detector reports whether its input is above an arming level and whether it is below a trigger level; two current comparators report whether the sensed switch current has reached the multiplier reference and whether it has reached a much higher saturation level; two over-voltage comparators on the bus-sense node give an upper and a lower (hysteresis) level; and a flag reports that the voltage feedback input has dropped abnormally low. A global enable gates everything.

A pulse begins when the detector has been armed and then triggers, or, if no such event arrives, when a backup restart timer expires. The pulse ends when the current reaches the reference, with both current comparators masked for a programmable blanking interval at the start of each pulse. Bus over-voltage pauses switching with hysteresis; choke saturation and feedback disconnection are latched faults that hold the gate off until reset. Blanking length and restart period are inputs counted in clock cycles. Every output is registered, so each reaction appears one clock after the input sample that causes it.

Top module: `pfc_tm_gate`

## Requirements
- R1: While `rst` is high at a clock edge, `gate`, `sat_latch` and `ol_latch` become 0, the arm flag is cleared and both internal counters return to zero.
- R2: When the arm flag is set and `zcd_trig` is sampled 1 after having been sampled 0 on the previous edge, with the gate low and switching permitted, `gate` is 1 from the next cycle on.
- R3: The arm flag is set by any cycle in which `zcd_arm` is 1 and cleared on the edge where the gate turns on; a rising `zcd_trig` while the flag is clear does not turn the gate on.
- R4: During the first `blank_cyc` cycles of each pulse, `cs_ref` and `cs_sat` are ignored; after that, `cs_ref` = 1 makes `gate` 0 on the next cycle, so with `cs_ref` held high a pulse lasts `blank_cyc`+1 cycles.
- R5: After the gate falls, if no valid trigger arrives, `gate` rises again after exactly `restart_cyc` low cycles (for `restart_cyc` ≥ 1); the restart count restarts from zero at every pulse and whenever switching is not permitted.
- R6: `en` = 0 makes `gate` 0 on the next cycle and keeps it there; `en` does not clear `sat_latch` or `ol_latch`.
- R7: `ovp_set` = 1 stops switching from the next cycle; the pause lasts while `ovp_hold` stays 1 and ends in the first cycle `ovp_hold` is 0 with `ovp_set` also 0, without latching.
- R8: `cs_sat` = 1 while the gate is high and past blanking sets `sat_latch` on the next cycle, even in the same cycle as `cs_ref`; from then `gate` stays 0 until reset.
- R9: `ovp_set` = 1 and `fb_low` = 1 in the same cycle set `ol_latch` and force `gate` to 0 on the next cycle; both hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global switching enable |
| zcd_arm | input | 1 | Detector input above the arming level |
| zcd_trig | input | 1 | Detector input below the trigger level |
| cs_ref | input | 1 | Switch current at or above the multiplier reference |
| cs_sat | input | 1 | Switch current at or above the saturation level |
| ovp_set | input | 1 | Bus-sense above the upper over-voltage level |
| ovp_hold | input | 1 | Bus-sense above the lower (release) level |
| fb_low | input | 1 | Feedback input below its disconnection level |
| blank_cyc | input | 8 | Blanking length in cycles |
| restart_cyc | input | 12 | Restart timer period in cycles |
| gate | output | 1 | Switch gate command |
| sat_latch | output | 1 | Choke saturation fault latched |
| ol_latch | output | 1 | Feedback disconnection fault latched |

## Verification
The interesting collision is pulse termination by the reference comparator and the saturation fault landing in the very same cycle: both act only after blanking and both pull the gate low, but only one of them must leave a permanent latch. The bench opens a pulse, keeps both current flags low through the blanking interval, then raises `cs_ref` and `cs_sat` together and expects the gate to fall and `sat_latch` to rise on the following cycle, with no further pulse afterwards despite detector and starter activity. A behavioural model in the bench follows every cycle of directed and random stimulus, and directed counts confirm pulse width and restart spacing.

// File: rtl/pfc_tm_pkg.sv
package pfc_tm_pkg;

    localparam int BLANK_W = 8;
    localparam int IDLE_W  = 12;

    typedef struct packed {
        logic sat;    // choke saturation latched
        logic ol;     // feedback disconnection latched
        logic pause;  // over-voltage pause in progress
    } guard_t;

    function automatic logic [BLANK_W-1:0] blank_inc(input logic [BLANK_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    function automatic logic [IDLE_W-1:0] idle_inc(input logic [IDLE_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/pfc_zcd_arm.sv
module pfc_zcd_arm (
    input  logic clk,
    input  logic rst,
    input  logic zcd_arm,
    input  logic zcd_trig,
    input  logic turn_on,
    output logic armed,
    output logic trig_edge
);
    logic arm_q;
    logic trig_q;

    assign armed     = arm_q;
    assign trig_edge = zcd_trig & ~trig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q  <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            trig_q <= zcd_trig;
            if (turn_on)
                arm_q <= 1'b0;
            else if (zcd_arm)
                arm_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pfc_guard.sv
module pfc_guard
    import pfc_tm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ovp_set,
    input  logic   ovp_hold,
    input  logic   fb_low,
    input  logic   sat_hit,
    output guard_t grd_n,
    output guard_t grd_q
);
    always_comb begin
        grd_n.sat   = grd_q.sat | sat_hit;
        grd_n.ol    = grd_q.ol  | (ovp_set & fb_low);
        if (ovp_set)
            grd_n.pause = 1'b1;
        else if (!ovp_hold)
            grd_n.pause = 1'b0;
        else
            grd_n.pause = grd_q.pause;
    end

    always_ff @(posedge clk) begin
        if (rst)
            grd_q <= '0;
        else
            grd_q <= grd_n;
    end
endmodule

// File: rtl/pfc_timer.sv
module pfc_timer
    import pfc_tm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               gate_q,
    input  logic               gate_n,
    input  logic               start,
    input  logic               run,
    input  logic [BLANK_W-1:0] blank_cyc,
    input  logic [IDLE_W-1:0]  restart_cyc,
    output logic               blank_done,
    output logic               restart_due
);
    logic [BLANK_W-1:0] on_q;
    logic [IDLE_W-1:0]  idle_q;

    assign blank_done  = gate_q & (on_q >= blank_cyc);
    assign restart_due = (idle_q >= restart_cyc);

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q   <= '0;
            idle_q <= '0;
        end else begin
            if (start)
                on_q <= '0;
            else if (gate_q)
                on_q <= blank_inc(on_q);

            if (gate_n || !run)
                idle_q <= '0;
            else
                idle_q <= idle_inc(idle_q);
        end
    end
endmodule

// File: rtl/pfc_tm_gate.sv
module pfc_tm_gate
    import pfc_tm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               zcd_arm,
    input  logic               zcd_trig,
    input  logic               cs_ref,
    input  logic               cs_sat,
    input  logic               ovp_set,
    input  logic               ovp_hold,
    input  logic               fb_low,
    input  logic [BLANK_W-1:0] blank_cyc,
    input  logic [IDLE_W-1:0]  restart_cyc,
    output logic               gate,
    output logic               sat_latch,
    output logic               ol_latch
);
    logic   gate_q, gate_n;
    logic   armed, trig_edge;
    logic   blank_done, restart_due;
    logic   run, start, stop, sat_hit;
    guard_t grd_n, grd_q;

    pfc_zcd_arm u_zcd (
        .clk(clk), .rst(rst), .zcd_arm(zcd_arm), .zcd_trig(zcd_trig),
        .turn_on(start), .armed(armed), .trig_edge(trig_edge)
    );

    pfc_guard u_guard (
        .clk(clk), .rst(rst), .ovp_set(ovp_set), .ovp_hold(ovp_hold),
        .fb_low(fb_low), .sat_hit(sat_hit), .grd_n(grd_n), .grd_q(grd_q)
    );

    pfc_timer u_timer (
        .clk(clk), .rst(rst), .gate_q(gate_q), .gate_n(gate_n),
        .start(start), .run(run), .blank_cyc(blank_cyc),
        .restart_cyc(restart_cyc), .blank_done(blank_done),
        .restart_due(restart_due)
    );

    assign sat_hit = blank_done & cs_sat;
    assign stop    = blank_done & cs_ref;
    assign run     = en & ~grd_n.sat & ~grd_n.ol & ~grd_n.pause;
    assign start   = ~gate_q & run & ((armed & trig_edge) | restart_due);
    assign gate_n  = run & (start | (gate_q & ~stop));

    always_ff @(posedge clk) begin
        if (rst)
            gate_q <= 1'b0;
        else
            gate_q <= gate_n;
    end

    assign gate      = gate_q;
    assign sat_latch = grd_q.sat;
    assign ol_latch  = grd_q.ol;
endmodule

// File: rtl/pfc_tm_gate_chk.sv
module pfc_tm_gate_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic ovp_set,
    input logic fb_low,
    input logic gate,
    input logic sat_latch,
    input logic ol_latch,
    input logic armed
);
    a_r6_disable_gate: assert property (@(posedge clk) disable iff (rst)
        !en |=> !gate);

    a_r8_sat_sticky: assert property (@(posedge clk) disable iff (rst)
        sat_latch |=> sat_latch);

    a_r8_sat_blocks_gate: assert property (@(posedge clk) disable iff (rst)
        sat_latch |-> !gate);

    a_r9_ol_set: assert property (@(posedge clk) disable iff (rst)
        (ovp_set && fb_low) |=> (ol_latch && !gate));

    a_r9_ol_sticky: assert property (@(posedge clk) disable iff (rst)
        ol_latch |=> ol_latch);

    a_r9_ol_blocks_gate: assert property (@(posedge clk) disable iff (rst)
        ol_latch |-> !gate);

    a_r7_ovp_pause: assert property (@(posedge clk) disable iff (rst)
        ovp_set |=> !gate);

    a_r3_arm_cleared: assert property (@(posedge clk) disable iff (rst)
        $rose(gate) |-> !armed);
endmodule

bind pfc_tm_gate pfc_tm_gate_chk u_chk (
    .clk(clk), .rst(rst), .en(en), .ovp_set(ovp_set), .fb_low(fb_low),
    .gate(gate), .sat_latch(sat_latch), .ol_latch(ol_latch), .armed(armed)
);

// File: tb/pfc_tm_gate_test.sv
module pfc_tm_gate_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0, zcd_arm = 1'b0, zcd_trig = 1'b0;
    logic        cs_ref = 1'b0, cs_sat = 1'b0;
    logic        ovp_set = 1'b0, ovp_hold = 1'b0, fb_low = 1'b0;
    logic [7:0]  blank_cyc = 8'd3;
    logic [11:0] restart_cyc = 12'd10;
    logic        gate, sat_latch, ol_latch;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string phase_req = "R1";

    always #2 clk = ~clk;

    pfc_tm_gate uut (
        .clk(clk), .rst(rst), .en(en), .zcd_arm(zcd_arm), .zcd_trig(zcd_trig),
        .cs_ref(cs_ref), .cs_sat(cs_sat), .ovp_set(ovp_set), .ovp_hold(ovp_hold),
        .fb_low(fb_low), .blank_cyc(blank_cyc), .restart_cyc(restart_cyc),
        .gate(gate), .sat_latch(sat_latch), .ol_latch(ol_latch)
    );

    // Behavioural reference: state as plain integers, one update per edge
    int m_gate = 0, m_sat = 0, m_ol = 0, m_pause = 0, m_arm = 0;
    int m_prev_trig = 0, m_hi_cycles = 0, m_lo_cycles = 0;

    always @(posedge clk) begin
        int ovr, sat_now, ol_now, pause_now, allowed, fire, ends, nxt;
        if (rst) begin
            m_gate = 0; m_sat = 0; m_ol = 0; m_pause = 0; m_arm = 0;
            m_prev_trig = 0; m_hi_cycles = 0; m_lo_cycles = 0;
        end else begin
            ovr       = (m_gate != 0) && (m_hi_cycles >= blank_cyc);
            sat_now   = m_sat | (ovr & cs_sat);
            ol_now    = m_ol | (ovp_set & fb_low);
            pause_now = ovp_set ? 1 : (ovp_hold ? m_pause : 0);
            allowed   = en && !sat_now && !ol_now && !pause_now;
            fire      = !m_gate && allowed &&
                        ((m_arm && zcd_trig && !m_prev_trig) || (m_lo_cycles >= restart_cyc));
            ends      = ovr && cs_ref;
            nxt       = allowed && (fire || (m_gate && !ends));
            if (fire) m_hi_cycles = 0;
            else if (m_gate && m_hi_cycles < 255) m_hi_cycles++;
            if (nxt || !allowed) m_lo_cycles = 0;
            else if (m_lo_cycles < 4095) m_lo_cycles++;
            if (fire) m_arm = 0;
            else if (zcd_arm) m_arm = 1;
            m_prev_trig = zcd_trig;
            m_sat = sat_now; m_ol = ol_now; m_pause = pause_now; m_gate = nxt;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check(phase_req, "gate vs model", int'(gate), m_gate);
            check(phase_req, "sat_latch vs model", int'(sat_latch), m_sat);
            check(phase_req, "ol_latch vs model", int'(ol_latch), m_ol);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_gate(input logic lvl, input int limit, output int waited);
        waited = 0;
        while (gate !== lvl && waited < limit) begin
            tick(1);
            waited++;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        en = 0; zcd_arm = 0; zcd_trig = 0; cs_ref = 0; cs_sat = 0;
        ovp_set = 0; ovp_hold = 0; fb_low = 0;
        tick(3);
        rst = 1'b0;
    endtask

    initial begin
        int w, cnt;
        // R1: reset state
        phase_req = "R1";
        tick(3);
        check("R1", "gate in reset", int'(gate), 0);
        check("R1", "sat_latch in reset", int'(sat_latch), 0);
        check("R1", "ol_latch in reset", int'(ol_latch), 0);
        rst = 1'b0;

        // R5 / R4: starter pulse with cs_ref held high
        phase_req = "R5";
        cs_ref = 1; en = 1;
        wait_gate(1'b1, 60, w);
        check("R5", "starter fired", int'(gate), 1);
        cnt = 0;
        while (gate === 1'b1 && cnt < 50) begin tick(1); cnt++; end
        check("R4", "pulse width = blank_cyc+1", cnt, 4);
        cnt = 0;
        while (gate === 1'b0 && cnt < 50) begin tick(1); cnt++; end
        check("R5", "low cycles before restart", cnt, 10);
        wait_gate(1'b0, 20, w);

        // R3 / R2: trigger without and with arming, starter disabled
        phase_req = "R3";
        restart_cyc = 12'd4000;
        tick(2);
        zcd_trig = 1; tick(1); zcd_trig = 0;
        tick(3);
        check("R3", "unarmed trigger ignored", int'(gate), 0);
        phase_req = "R2";
        zcd_arm = 1; tick(1); zcd_arm = 0; tick(1);
        zcd_trig = 1; tick(1);
        check("R2", "armed trigger turns on", int'(gate), 1);
        zcd_trig = 0;
        wait_gate(1'b0, 20, w);
        zcd_trig = 1; tick(1); zcd_trig = 0; tick(2);
        phase_req = "R3";
        check("R3", "arm cleared at turn-on", int'(gate), 0);

        // R7: over-voltage pause with hysteresis
        phase_req = "R7";
        restart_cyc = 12'd10;
        ovp_set = 1; ovp_hold = 1; tick(1); ovp_set = 0;
        cnt = 0;
        repeat (30) begin tick(1); if (gate) cnt++; end
        check("R7", "gate pulses while paused", cnt, 0);
        ovp_hold = 0;
        wait_gate(1'b1, 30, w);
        check("R7", "switching resumed", int'(gate), 1);

        // R6: enable low
        phase_req = "R6";
        en = 0; tick(1);
        cnt = 0;
        repeat (25) begin tick(1); if (gate) cnt++; end
        check("R6", "gate pulses while disabled", cnt, 0);
        en = 1;

        // Random mix without latching faults
        phase_req = "R2";
        blank_cyc = 8'd2; restart_cyc = 12'd6;
        for (int i = 0; i < 3000; i++) begin
            zcd_arm  = ($urandom % 4) == 0;
            zcd_trig = ($urandom % 3) == 0;
            cs_ref   = ($urandom % 3) == 0;
            ovp_set  = ($urandom % 50) == 0;
            ovp_hold = ($urandom % 4) != 0;
            en       = ($urandom % 40) != 0;
            tick(1);
        end
        zcd_arm = 0; zcd_trig = 0; cs_ref = 0; ovp_set = 0; ovp_hold = 0; en = 1;
        blank_cyc = 8'd3; restart_cyc = 12'd10;

        // R4 then R8: saturation masked during blanking, then coincident with cs_ref
        phase_req = "R4";
        wait_gate(1'b0, 100, w);
        wait_gate(1'b1, 100, w);
        cs_sat = 1; tick(3); cs_sat = 0; tick(1);
        check("R4", "saturation masked in blanking", int'(sat_latch), 0);
        check("R4", "pulse continues", int'(gate), 1);
        phase_req = "R8";
        cs_ref = 1; cs_sat = 1; tick(1);
        cs_ref = 0; cs_sat = 0;
        check("R8", "sat latch set", int'(sat_latch), 1);
        check("R8", "gate off on saturation", int'(gate), 0);
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            zcd_arm = (i % 5) == 0; zcd_trig = (i % 5) == 2;
            tick(1); if (gate) cnt++;
        end
        check("R8", "no pulses after saturation", cnt, 0);
        en = 0; tick(2);
        check("R6", "enable does not clear sat latch", int'(sat_latch), 1);

        // R9: feedback disconnection
        phase_req = "R9";
        do_reset();
        en = 1; tick(20);
        ovp_set = 1; fb_low = 1; tick(1);
        ovp_set = 0; fb_low = 0;
        check("R9", "open-loop latch set", int'(ol_latch), 1);
        check("R9", "gate forced off", int'(gate), 0);
        cnt = 0;
        repeat (40) begin tick(1); if (gate) cnt++; end
        check("R9", "no pulses after open-loop", cnt, 0);
        check("R9", "open-loop latch holds", int'(ol_latch), 1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule